// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low by a slave that was cut off mid-byte, for example when the master was reset during a read. On a start request it takes the SCL and SDA pins away from the normal I2C engine. It then toggles SCL itself while only watching SDA. After each clock pulse it checks whether the slave has let go of SDA. It gives at most nine pulses. It then writes a STOP condition step by step and hands the pins back to the engine, with a reset pulse to that engine.

The pin outputs are open-drain pull-down enables: a high enable pulls the wire low, and a low enable lets the pull-up take it high. The toggle rate comes from a half-period parameter counted in system clocks. It should be set well below 100 kHz so that a slave in any internal state can follow it. The SDA pin is read through a two-stage synchronizer. A one-cycle completion pulse carries a status bit that tells whether SDA was still low after the last allowed pulse.

Top module: `i2c_unstick_top`

## Requirements
- R1: After reset the block is idle: neither pin is pulled low, pin ownership stays with the engine (`engineHold` = 0), and `done` and `engineReset` are 0.
- R2: A start request seen while idle sets `engineHold` from the next cycle and pulls SCL low in that cycle. SDA is never pulled low during the clocking phase.
- R3: Each recovery pulse pulls SCL low for exactly HALF_CYCLES clocks and then releases it for exactly HALF_CYCLES clocks.
- R4: SDA is judged on its synchronized value in the last clock of each released-SCL phase. Clocking stops after the first pulse that finds SDA high, and never goes beyond MAX_PULSES (9) pulses.
- R5: The STOP is made of four steps of HALF_CYCLES clocks each, in this order: SCL pulled low, SDA also pulled low, SCL released, SDA released. SDA is therefore pulled low only while SCL is low, and released only while SCL is high.
- R6: In the cycle after the STOP ends, `done` and `engineReset` are high together for exactly one cycle and `engineHold` is low. So `engineHold` lasts (2*pulses + 4)*HALF_CYCLES cycles.
- R7: `stuck` is 1 when SDA was still low after the ninth pulse, and 0 when it was released at any earlier or equal pulse. It is valid with `done` and holds until the next run.
- R8: A start request that arrives while a recovery is running, including its `done` cycle, is ignored: the run's length and outcome are unchanged and no second run follows.
- R9: At least one pulse is always given, even if SDA is already high when the start is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to run a recovery (acted on only when idle) |
| sdaPin | input | 1 | Raw level of the SDA wire |
| sclDriveLow | output | 1 | Pull SCL low while high |
| sdaDriveLow | output | 1 | Pull SDA low while high |
| engineHold | output | 1 | Pins owned by the sequencer; engine drive disabled |
| engineReset | output | 1 | One-cycle reset to the I2C engine on completion |
| done | output | 1 | One-cycle completion pulse |
| stuck | output | 1 | SDA still low after the last pulse |

## Verification
The assertions assume that `startReq` and `sdaPin` change only between clock edges, and that `sdaPin` stays stable for at least three clocks before a decision point. They also assume that the SDA wire can be pulled low only by the sequencer or by the slave. The bench holds to this with a slave model. The model reads the SCL wire away from the active edge, counts its rising edges, and releases SDA after a chosen count. The count is swept from zero to beyond nine, which covers every early exit, the exhaustion case and the already-released case. One run also injects a start request in the middle of the recovery.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_STOP_SCL_LO,
    ST_STOP_SDA_LO,
    ST_STOP_SCL_HI,
    ST_STOP_SDA_HI,
    ST_FINISH
  } recState_t;

  typedef struct packed {
    logic loadHalf;
    logic clrRun;
    logic incPulse;
    logic latchStuck;
  } recStrobe_t;

endpackage

// File: rtl/i2c_unstick_path.sv
module i2c_unstick_path
  import i2c_unstick_pkg::*;
#(
  parameter int HALF_CYCLES = 5000,
  parameter int MAX_PULSES  = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  recStrobe_t strobe,
  input  logic       sdaPin,
  output logic       halfDone,
  output logic       lastPulse,
  output logic       sdaHigh,
  output logic       stuckFlag
);

  localparam int HALF_W  = $clog2(HALF_CYCLES + 1);
  localparam int PULSE_W = $clog2(MAX_PULSES + 1);

  logic [HALF_W-1:0]  halfCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic [1:0]         sdaSync;

  // two-stage synchronizer on the open-drain data wire
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaSync <= 2'b11;
    else       sdaSync <= {sdaSync[0], sdaPin};
  end
  assign sdaHigh = sdaSync[1];

  // half-period timer: loads HALF_CYCLES-1 and counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                halfCnt <= '0;
    else if (strobe.loadHalf) halfCnt <= HALF_W'(HALF_CYCLES - 1);
    else if (halfCnt != '0)   halfCnt <= halfCnt - 1'b1;
  end
  assign halfDone = (halfCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strobe.clrRun)   pulseCnt <= '0;
    else if (strobe.incPulse) pulseCnt <= pulseCnt + 1'b1;
  end
  assign lastPulse = (pulseCnt == PULSE_W'(MAX_PULSES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stuckFlag <= 1'b0;
    else if (strobe.clrRun)     stuckFlag <= 1'b0;
    else if (strobe.latchStuck) stuckFlag <= ~sdaHigh;
  end

endmodule

// File: rtl/i2c_unstick_ctrl.sv
module i2c_unstick_ctrl
  import i2c_unstick_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       halfDone,
  input  logic       lastPulse,
  input  logic       sdaHigh,
  output recStrobe_t strobe,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       engineHold,
  output logic       engineReset,
  output logic       done
);

  recState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stateNext       = ST_PULSE_LO;
        strobe.loadHalf = 1'b1;
        strobe.clrRun   = 1'b1;
      end
      ST_PULSE_LO: if (halfDone) begin
        stateNext       = ST_PULSE_HI;
        strobe.loadHalf = 1'b1;
      end
      ST_PULSE_HI: if (halfDone) begin
        strobe.loadHalf = 1'b1;
        strobe.incPulse = 1'b1;
        if (sdaHigh || lastPulse) begin
          stateNext         = ST_STOP_SCL_LO;
          strobe.latchStuck = 1'b1;
        end else begin
          stateNext = ST_PULSE_LO;
        end
      end
      ST_STOP_SCL_LO: if (halfDone) begin
        stateNext       = ST_STOP_SDA_LO;
        strobe.loadHalf = 1'b1;
      end
      ST_STOP_SDA_LO: if (halfDone) begin
        stateNext       = ST_STOP_SCL_HI;
        strobe.loadHalf = 1'b1;
      end
      ST_STOP_SCL_HI: if (halfDone) begin
        stateNext       = ST_STOP_SDA_HI;
        strobe.loadHalf = 1'b1;
      end
      ST_STOP_SDA_HI: if (halfDone) stateNext = ST_FINISH;
      ST_FINISH:      stateNext = ST_IDLE;
      default:        stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    sclDriveLow = (state == ST_PULSE_LO) || (state == ST_STOP_SCL_LO) ||
                  (state == ST_STOP_SDA_LO);
    sdaDriveLow = (state == ST_STOP_SDA_LO) || (state == ST_STOP_SCL_HI);
    engineHold  = (state != ST_IDLE) && (state != ST_FINISH);
    done        = (state == ST_FINISH);
    engineReset = (state == ST_FINISH);
  end

endmodule

// File: rtl/i2c_unstick_top.sv
module i2c_unstick_top
  import i2c_unstick_pkg::*;
#(
  parameter int HALF_CYCLES = 5000,
  parameter int MAX_PULSES  = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic sdaPin,
  output logic sclDriveLow,
  output logic sdaDriveLow,
  output logic engineHold,
  output logic engineReset,
  output logic done,
  output logic stuck
);

  recStrobe_t strobe;
  logic halfDone, lastPulse, sdaHigh;

  i2c_unstick_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .halfDone(halfDone), .lastPulse(lastPulse), .sdaHigh(sdaHigh),
    .strobe(strobe), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .engineHold(engineHold), .engineReset(engineReset), .done(done)
  );

  i2c_unstick_path #(.HALF_CYCLES(HALF_CYCLES), .MAX_PULSES(MAX_PULSES)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaPin(sdaPin),
    .halfDone(halfDone), .lastPulse(lastPulse), .sdaHigh(sdaHigh),
    .stuckFlag(stuck)
  );

endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic sdaPin,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic engineHold,
  input logic engineReset,
  input logic done,
  input logic stuck
);

  localparam int CNT_W = $clog2(MAX_PULSES + 2) + 1;
  logic [CNT_W-1:0] relCnt;
  logic             seenClk;

  // counts SCL releases made in the clocking phase of the current run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relCnt  <= '0;
      seenClk <= 1'b0;
    end else begin
      seenClk <= 1'b1;
      if (!engineHold) relCnt <= '0;
      else if (seenClk && !sclDriveLow && !sdaDriveLow &&
               $past(sclDriveLow) && !$past(sdaDriveLow))
        relCnt <= relCnt + 1'b1;
    end
  end

  p_idle_no_drive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !engineHold |-> (!sclDriveLow && !sdaDriveLow));

  p_sda_only_in_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> engineHold);

  p_pulse_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    relCnt <= CNT_W'(MAX_PULSES));

  p_sda_low_under_scl_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> (sclDriveLow && $past(sclDriveLow)));

  p_sda_release_scl_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> (!sclDriveLow && $past(!sclDriveLow)));

  p_done_with_reset_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (engineReset && !engineHold));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_handback_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(engineHold) |-> done);

  p_stuck_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (engineHold && !$rose(engineHold) && !sdaDriveLow && !sclDriveLow &&
     $past(sdaDriveLow)) |-> $stable(stuck));

endmodule

bind i2c_unstick_top i2c_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .sdaPin(sdaPin),
  .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .engineHold(engineHold), .engineReset(engineReset), .done(done),
  .stuck(stuck)
);

// File: tb/i2c_unstick_top_bench.sv
module i2c_unstick_top_bench;

  localparam int HALF = 6;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic slaveLow = 1'b1;
  logic sclDriveLow, sdaDriveLow, engineHold, engineReset, done, stuck;
  logic sdaPin;

  int tests = 0;
  int fails = 0;

  assign sdaPin = !(slaveLow || sdaDriveLow);

  always #2 clk = ~clk;

  i2c_unstick_top #(.HALF_CYCLES(HALF), .MAX_PULSES(MAXP)) u_i2c_unstick_top (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdaPin(sdaPin),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .engineHold(engineHold), .engineReset(engineReset), .done(done),
    .stuck(stuck)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one recovery; slave lets go of SDA after relEdges rising SCL edges
  task automatic runCase(int relEdges, int injectAt);
    int edges = 0, cyc = 0, holdCycles = 0, pulses = 0, runLen = 0;
    int badWidth = 0, badOrder = 0, sdaBeforeStop = 0;
    int expP, sawDone = 0, erst = 0, stk = 0, hold0 = 0;
    logic prevScl = 1'b1, prevDrv = 1'b0, prevSda = 1'b0, sclLine;
    expP = (relEdges < 1) ? 1 : ((relEdges > MAXP) ? MAXP : relEdges);
    slaveLow = (relEdges > 0);
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check("R2 hold after start", int'(engineHold), 1);
    check("R2 scl low after start", int'(sclDriveLow), 1);
    while (cyc < 2000) begin
      sclLine = !sclDriveLow;
      if (sclLine && !prevScl) edges++;
      prevScl = sclLine;
      slaveLow = (edges < relEdges);
      startReq = (injectAt != 0 && cyc == injectAt);
      if (done) begin
        sawDone = 1; erst = int'(engineReset); stk = int'(stuck);
        hold0 = int'(!engineHold);
        break;
      end
      if (engineHold) holdCycles++;
      if (sdaDriveLow && pulses < expP) sdaBeforeStop++;
      if (sclDriveLow && !sdaDriveLow) runLen++;
      if (prevDrv && !sclDriveLow && !sdaDriveLow && !prevSda) begin
        pulses++;
        if (runLen != HALF) badWidth++;
      end
      if (!sclDriveLow) runLen = 0;
      if (sdaDriveLow && !prevSda && !sclDriveLow) badOrder++;
      if (!sdaDriveLow && prevSda && sclDriveLow) badOrder++;
      prevDrv = sclDriveLow;
      prevSda = sdaDriveLow;
      @(negedge clk); cyc++;
    end
    startReq = 1'b0;
    check("R6 done seen", sawDone, 1);
    check("R4/R9 pulse count", pulses, expP);
    check("R3 low phase width", badWidth, 0);
    check("R2 no SDA drive while clocking", sdaBeforeStop, 0);
    check("R5 STOP ordering", badOrder, 0);
    check("R6 hold length", holdCycles, (2 * expP + 4) * HALF);
    check("R6 engineReset with done", erst, 1);
    check("R6 hold low at done", hold0, 1);
    check("R7 stuck status", stk, (relEdges > MAXP) ? 1 : 0);
    @(negedge clk);
    check("R6 done single cycle", int'(done), 0);
    for (int i = 0; i < 3 * HALF; i++) begin
      if (engineHold || sclDriveLow) begin
        check("R8 no second run", 1, 0);
        break;
      end
      @(negedge clk);
    end
    check("R7 stuck held after run", int'(stuck), (relEdges > MAXP) ? 1 : 0);
  endtask

  initial begin
    #200000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset scl", int'(sclDriveLow), 0);
    check("R1 reset sda", int'(sdaDriveLow), 0);
    check("R1 reset hold", int'(engineHold), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset engineReset", int'(engineReset), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle without start", int'(engineHold), 0);
    for (int n = 0; n <= 11; n++) runCase(n, 0);
    runCase(1000, 0);
    // R8: start requests mid-run and in the run's final stages
    runCase(3, 10);
    runCase(4, (2 * 4 + 4) * HALF - 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule